// File: doc/BRIEF.md
# Programming Frame Receiver and Validator

This block sits behind a serial receiver that has already turned the line into whole bytes, offered one at a time with a valid strobe. It parses two kinds of frame used by a flash-programming protocol. A command frame carries a command code and optional parameter bytes. A data frame carries up to 256 payload bytes. Each frame ends with a subtractive checksum and an end byte.

While a frame arrives, the block streams its body bytes out one per cycle. These are the parameter bytes of a command frame or the payload bytes of a data frame. It keeps the frame kind and the most recent command code on its outputs. For data frames it records whether another data frame is announced to follow. When a frame completes or is aborted, it pulses a one-byte status code for the response logic further down the line. An inter-byte timeout, set from a port, drops a stalled frame and returns the parser to idle without reporting anything.

Top module: `pgm_frame_rx`

## Requirements
- R1: While idle, any byte other than 0x01 or 0x02 is discarded. It produces no stream byte and no status, and it leaves the kind, command and follow-on outputs unchanged.
- R2: Header 0x01 opens a command frame and drives `frame_is_data` low. Header 0x02 opens a data frame and drives `frame_is_data` high. Both take effect one cycle after the header byte is accepted.
- R3: In a command frame the byte after the length is the command code. It appears on `cmd_code` one cycle later and is not streamed. Every parameter or payload byte appears on `body_byte`, with `body_valid` high for one cycle, one cycle after it is accepted.
- R4: The expected checksum is 0x00 minus the length byte minus every body byte, including the command code, modulo 256. A mismatch with a correct end byte gives status 0x07.
- R5: A frame with a correct end byte, a matching checksum and, for a command frame, a supported code gives status 0x06. The status appears with `status_valid` high for one cycle, one cycle after the end byte.
- R6: The supported command codes are 0x00, 0x9A, 0x20, 0x22, 0x40, 0x13, 0x32, 0xC0, 0xC5, 0xB0 and 0xA0. Any other code in an otherwise good command frame gives status 0x04.
- R7: An end byte other than 0x03, or other than 0x03 or 0x17 for a data frame, gives status 0x15.
- R8: A command frame whose length byte is 0x00 is aborted with status 0x15 one cycle after the length byte. The bytes that follow are then treated as idle input.
- R9: A data-frame length byte of 0x00 means 256 payload bytes.
- R10: A good data-frame end byte of 0x17 sets `more_follow`, and 0x03 clears it, one cycle after the end byte. A bad end byte leaves it unchanged.
- R11: If `timeout_cycles` is non-zero and that many consecutive cycles pass inside a frame without a byte, the parser returns to idle and issues no status. A value of zero disables the timeout.
- R12: After reset, `body_valid` and `status_valid` are low, and `frame_is_data`, `cmd_code` and `more_follow` are zero.
- R13: The status checks run in a fixed order: a bad end byte (0x15) first, then a checksum mismatch (0x07), then an unsupported code (0x04).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A received byte is present this cycle |
| in_byte | input | 8 | Received byte |
| timeout_cycles | input | TMO_W | Idle cycles inside a frame before it is dropped; 0 disables the timeout |
| body_valid | output | 1 | One-cycle strobe for a streamed body byte |
| body_byte | output | 8 | Streamed parameter or payload byte |
| frame_is_data | output | 1 | Kind of the current or most recent frame (1 = data) |
| cmd_code | output | 8 | Most recent command code |
| more_follow | output | 1 | The last good data frame announced a further frame |
| status_valid | output | 1 | One-cycle strobe for the frame outcome |
| status_code | output | 8 | Outcome code: 0x06, 0x04, 0x07 or 0x15 |

## Verification
The bench goes after the 256-byte data frame given by a zero length. A design with an 8-bit counter would close that frame at once and report a checksum or end-byte fault. It sends frames that are bad in two ways at once, to expose a wrong status priority. It sends a zero-length command frame, where a design that skipped the abort would take the next byte as a command code. It stalls a frame exactly at the timeout limit and one cycle short of it, which catches an off-by-one counter or a timeout that leaks a status. Garbage bytes between frames check that an idle parser ignores them and does not open a frame.

// File: rtl/pgm_frame_pkg.sv
package pgm_frame_pkg;
   localparam logic [7:0] HDR_CMD  = 8'h01;
   localparam logic [7:0] HDR_DAT  = 8'h02;
   localparam logic [7:0] END_LAST = 8'h03;
   localparam logic [7:0] END_MORE = 8'h17;

   localparam logic [7:0] ST_UNSUP = 8'h04;
   localparam logic [7:0] ST_ACK   = 8'h06;
   localparam logic [7:0] ST_CSUM  = 8'h07;
   localparam logic [7:0] ST_NAK   = 8'h15;

   typedef enum logic [2:0] {
      P_IDLE, P_LEN, P_CODE, P_BODY, P_SUM, P_END
   } parse_t;

   function automatic logic code_known(input logic [7:0] c);
      case (c)
         8'h00, 8'h9A, 8'h20, 8'h22, 8'h40, 8'h13,
         8'h32, 8'hC0, 8'hC5, 8'hB0, 8'hA0: code_known = 1'b1;
         default:                           code_known = 1'b0;
      endcase
   endfunction
endpackage

// File: rtl/pgm_frame_csum.sv
module pgm_frame_csum #(
   parameter int BW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          seed,
   input  logic          sub,
   input  logic [BW-1:0] din,
   output logic [BW-1:0] acc
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    acc <= '0;
      else if (seed) acc <= '0 - din;
      else if (sub)  acc <= acc - din;
   end
endmodule

// File: rtl/pgm_frame_cmdchk.sv
module pgm_frame_cmdchk #(
   parameter bit ACCEPT_ALL = 1'b0
) (
   input  logic [7:0] code,
   output logic       known
);
   import pgm_frame_pkg::*;
   generate
      if (ACCEPT_ALL) begin : g_any
         assign known = 1'b1;
      end else begin : g_list
         assign known = code_known(code);
      end
   endgenerate
endmodule

// File: rtl/pgm_frame_tmo.sv
module pgm_frame_tmo #(
   parameter int TMO_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             busy,
   input  logic             in_valid,
   input  logic [TMO_W-1:0] limit,
   output logic             expire
);
   logic [TMO_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (in_valid || !busy) cnt_q <= '0;
      else if (!expire)          cnt_q <= cnt_q + 1'b1;
      else                       cnt_q <= '0;
   end

   assign expire = busy && !in_valid && (limit != '0) && (cnt_q == limit - 1'b1);
endmodule

// File: rtl/pgm_frame_rx.sv
module pgm_frame_rx #(
   parameter int TMO_W      = 16,
   parameter bit ACCEPT_ALL = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [7:0]       in_byte,
   input  logic [TMO_W-1:0] timeout_cycles,
   output logic             body_valid,
   output logic [7:0]       body_byte,
   output logic             frame_is_data,
   output logic [7:0]       cmd_code,
   output logic             more_follow,
   output logic             status_valid,
   output logic [7:0]       status_code
);
   import pgm_frame_pkg::*;

   localparam int BW    = 8;
   localparam int REM_W = BW + 1;

   generate
      if (TMO_W < 1 || TMO_W > 32) begin : g_bad_tmo
         $error("pgm_frame_rx: TMO_W out of range");
      end
   endgenerate

   parse_t           st_q;
   logic [REM_W-1:0] rem_q;
   logic             sum_ok_q;
   logic [BW-1:0]    acc;
   logic             known;
   logic             expire;
   logic             seed, sub, good_end;

   assign seed     = in_valid && (st_q == P_LEN);
   assign sub      = in_valid && (st_q == P_CODE || st_q == P_BODY);
   assign good_end = (in_byte == END_LAST) || (frame_is_data && in_byte == END_MORE);

   pgm_frame_csum #(.BW(BW)) u_csum (
      .clk(clk), .rst_n(rst_n), .seed(seed), .sub(sub), .din(in_byte), .acc(acc)
   );

   pgm_frame_cmdchk #(.ACCEPT_ALL(ACCEPT_ALL)) u_cmd (
      .code(cmd_code), .known(known)
   );

   pgm_frame_tmo #(.TMO_W(TMO_W)) u_tmo (
      .clk(clk), .rst_n(rst_n), .busy(st_q != P_IDLE), .in_valid(in_valid),
      .limit(timeout_cycles), .expire(expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q          <= P_IDLE;
         rem_q         <= '0;
         sum_ok_q      <= 1'b0;
         body_valid    <= 1'b0;
         body_byte     <= '0;
         frame_is_data <= 1'b0;
         cmd_code      <= '0;
         more_follow   <= 1'b0;
         status_valid  <= 1'b0;
         status_code   <= '0;
      end else begin
         body_valid   <= 1'b0;
         status_valid <= 1'b0;
         if (expire) begin
            st_q <= P_IDLE;
         end else if (in_valid) begin
            case (st_q)
               P_IDLE: begin
                  if (in_byte == HDR_CMD) begin
                     frame_is_data <= 1'b0;
                     st_q          <= P_LEN;
                  end else if (in_byte == HDR_DAT) begin
                     frame_is_data <= 1'b1;
                     st_q          <= P_LEN;
                  end
               end
               P_LEN: begin
                  if (!frame_is_data && in_byte == '0) begin
                     status_valid <= 1'b1;
                     status_code  <= ST_NAK;
                     st_q         <= P_IDLE;
                  end else if (frame_is_data) begin
                     rem_q <= (in_byte == '0) ? REM_W'(1 << BW) : REM_W'(in_byte);
                     st_q  <= P_BODY;
                  end else begin
                     rem_q <= REM_W'(in_byte);
                     st_q  <= P_CODE;
                  end
               end
               P_CODE: begin
                  cmd_code <= in_byte;
                  rem_q    <= rem_q - 1'b1;
                  st_q     <= (rem_q == REM_W'(1)) ? P_SUM : P_BODY;
               end
               P_BODY: begin
                  body_valid <= 1'b1;
                  body_byte  <= in_byte;
                  rem_q      <= rem_q - 1'b1;
                  if (rem_q == REM_W'(1)) st_q <= P_SUM;
               end
               P_SUM: begin
                  sum_ok_q <= (in_byte == acc);
                  st_q     <= P_END;
               end
               P_END: begin
                  status_valid <= 1'b1;
                  if (!good_end)                     status_code <= ST_NAK;
                  else if (!sum_ok_q)                status_code <= ST_CSUM;
                  else if (!frame_is_data && !known) status_code <= ST_UNSUP;
                  else                               status_code <= ST_ACK;
                  if (good_end && frame_is_data) more_follow <= (in_byte == END_MORE);
                  st_q <= P_IDLE;
               end
               default: st_q <= P_IDLE;
            endcase
         end
      end
   end

   // R5 / R13: only the four defined outcome codes can be reported
   a_r5_status_legal: assert property (@(posedge clk) disable iff (!rst_n)
      status_valid |-> (status_code == ST_ACK || status_code == ST_UNSUP ||
                        status_code == ST_CSUM || status_code == ST_NAK));

   // R3: a streamed byte and a status never share a cycle
   a_r3_stream_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(body_valid && status_valid));

   // R11: a timeout drops to idle and reports nothing
   a_r11_timeout_silent: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> (st_q == P_IDLE && !status_valid));

   // R8: zero-length command frame is refused right after its length byte
   a_r8_len_zero_nak: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == P_LEN && in_valid && !frame_is_data && in_byte == 8'h00 && !expire)
      |=> (status_valid && status_code == ST_NAK));

   // R10: an accepted data frame ending in the continue marker raises more_follow
   a_r10_more_set: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == P_END && in_valid && frame_is_data && in_byte == END_MORE)
      |=> more_follow);
endmodule

// File: tb/pgm_frame_rx_bench.sv
`timescale 1ns/1ps
module pgm_frame_rx_bench;
   localparam int TMO_W = 16;
   localparam int TMO   = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             in_valid = 1'b0;
   logic [7:0]       in_byte = '0;
   logic [TMO_W-1:0] timeout_cycles = TMO_W'(TMO);
   logic             body_valid, frame_is_data, more_follow, status_valid;
   logic [7:0]       body_byte, cmd_code, status_code;

   int checks = 0;
   int errors = 0;
   string cur_req = "R12";

   // expected outputs, valid after the next rising edge
   bit       e_bv = 0, e_sv = 0, e_data = 0, e_more = 0;
   int       e_bb = 0, e_sc = 0, e_cmd = 0;
   // behavioural model state
   int m_st = 0, m_rem = 0, m_sum = 0, m_idle = 0;
   bit m_ok = 0;
   int known[$] = '{8'h00, 8'h9A, 8'h20, 8'h22, 8'h40, 8'h13, 8'h32, 8'hC0, 8'hC5, 8'hB0, 8'hA0};

   always #2.5 clk = ~clk;

   pgm_frame_rx #(.TMO_W(TMO_W)) u_pgm_frame_rx (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
      .timeout_cycles(timeout_cycles), .body_valid(body_valid), .body_byte(body_byte),
      .frame_is_data(frame_is_data), .cmd_code(cmd_code), .more_follow(more_follow),
      .status_valid(status_valid), .status_code(status_code)
   );

   task automatic compare();
      bit bad = 0;
      checks++;
      if (body_valid !== e_bv || (e_bv && body_byte !== 8'(e_bb))) bad = 1;
      if (status_valid !== e_sv || (e_sv && status_code !== 8'(e_sc))) bad = 1;
      if (frame_is_data !== e_data || cmd_code !== 8'(e_cmd) || more_follow !== e_more) bad = 1;
      if (bad) begin
         errors++;
         $display("FAIL %s: got bv=%b bb=%h sv=%b sc=%h data=%b cmd=%h more=%b exp bv=%b bb=%h sv=%b sc=%h data=%b cmd=%h more=%b",
                  cur_req, body_valid, body_byte, status_valid, status_code, frame_is_data,
                  cmd_code, more_follow, e_bv, 8'(e_bb), e_sv, 8'(e_sc), e_data, 8'(e_cmd), e_more);
      end
   endtask

   function automatic bit is_known(int c);
      foreach (known[i]) if (known[i] == c) return 1;
      return 0;
   endfunction

   task automatic model(bit v, int b);
      e_bv = 0; e_sv = 0;
      if (!v) begin
         if (m_st != 0) begin
            m_idle++;
            if (TMO != 0 && m_idle == TMO) begin m_st = 0; m_idle = 0; end
         end else m_idle = 0;
      end else begin
         m_idle = 0;
         case (m_st)
            0: if (b == 1) begin e_data = 0; m_st = 1; end
               else if (b == 2) begin e_data = 1; m_st = 1; end
            1: begin
               m_sum = (256 - b) % 256;
               if (!e_data && b == 0) begin e_sv = 1; e_sc = 8'h15; m_st = 0; end
               else if (e_data) begin m_rem = (b == 0) ? 256 : b; m_st = 3; end
               else begin m_rem = b; m_st = 2; end
            end
            2: begin
               e_cmd = b; m_sum = (m_sum - b + 256) % 256; m_rem--;
               m_st = (m_rem == 0) ? 4 : 3;
            end
            3: begin
               e_bv = 1; e_bb = b; m_sum = (m_sum - b + 256) % 256; m_rem--;
               if (m_rem == 0) m_st = 4;
            end
            4: begin m_ok = (b == m_sum); m_st = 5; end
            default: begin
               e_sv = 1;
               if (!(b == 8'h03 || (e_data && b == 8'h17))) e_sc = 8'h15;
               else begin
                  if (!m_ok) e_sc = 8'h07;
                  else if (!e_data && !is_known(e_cmd)) e_sc = 8'h04;
                  else e_sc = 8'h06;
                  if (e_data) e_more = (b == 8'h17);
               end
               m_st = 0;
            end
         endcase
      end
   endtask

   task automatic step(bit v, int b);
      @(negedge clk);
      compare();
      in_valid = v;
      in_byte  = 8'(b);
      model(v, b);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) step(0, 0);
   endtask

   // header, length, body, checksum (optionally corrupted), end byte, gap cycles between bytes
   task automatic frame(int hdr, int len, int body[$], bit bad_sum, int endb, int gap);
      int s = (256 - len) % 256;
      foreach (body[i]) s = (s - body[i] + 256) % 256;
      if (bad_sum) s = s ^ 8'h5A;
      step(1, hdr); idle(gap);
      step(1, len); idle(gap);
      foreach (body[i]) begin step(1, body[i]); idle(gap); end
      step(1, s); idle(gap);
      step(1, endb);
      idle(2);
   endtask

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int big[$];
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cur_req = "R12"; idle(3);

      cur_req = "R1";  step(1, 8'h55); step(1, 8'h03); step(1, 8'h17); idle(2);
      cur_req = "R5";  frame(1, 1, '{8'h20}, 0, 8'h03, 0);
      cur_req = "R3";  frame(1, 4, '{8'h40, 8'h00, 8'h10, 8'hFE}, 0, 8'h03, 0);
      cur_req = "R2";  frame(2, 3, '{8'hAA, 8'h01, 8'h80}, 0, 8'h17, 1);
      cur_req = "R10"; frame(2, 2, '{8'h11, 8'h22}, 0, 8'h03, 0);
      cur_req = "R4";  frame(1, 2, '{8'hC5, 8'h33}, 1, 8'h03, 0);
      cur_req = "R6";  frame(1, 1, '{8'h55}, 0, 8'h03, 0);
      cur_req = "R6";  frame(1, 1, '{8'hA0}, 0, 8'h03, 0);
      cur_req = "R7";  frame(1, 1, '{8'h13}, 0, 8'h17, 0);
      cur_req = "R7";  frame(2, 1, '{8'h44}, 0, 8'h04, 0);
      cur_req = "R13"; frame(1, 1, '{8'h77}, 1, 8'h03, 0);
      cur_req = "R13"; frame(2, 1, '{8'h01}, 1, 8'h99, 0);
      cur_req = "R8";  step(1, 8'h01); step(1, 8'h00); step(1, 8'h20); step(1, 8'h03); idle(2);
      cur_req = "R9";
      for (int i = 0; i < 256; i++) big.push_back((i * 7 + 3) % 256);
      frame(2, 0, big, 0, 8'h03, 0);
      cur_req = "R11"; step(1, 8'h01); step(1, 8'h02); idle(TMO + 2);
      step(1, 8'h20); step(1, 8'h03); idle(2);
      cur_req = "R11"; frame(1, 2, '{8'h22, 8'h05}, 0, 8'h03, TMO - 1);
      cur_req = "R11"; step(1, 8'h02); step(1, 8'h01); idle(TMO);
      step(1, 8'h01); step(1, 8'h01); step(1, 8'h00); step(1, 8'hFF); step(1, 8'h03); idle(3);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule